// File: doc/BRIEF.md
# Polarity-Corrected Three-Phase Sine-Triangle Modulator

This block drives the six switches of a direct AC/AC converter whose supply is a single-phase, medium-frequency bipolar square wave. A shared up/down triangular carrier is compared against three sinusoidal references spaced a third of a cycle apart. This gives one pulse-width-modulated state per output phase. Each state is then inverted while the supply square wave is negative, so an ordinary inverter switching pattern stays correct on an input that keeps reversing sign.

Each output leg drives a complementary pair of switches. The block never lets the two switches of a leg swap directly unless the programmed blanking count is zero. Otherwise it first holds both switches off for that many clocks. Carrier period, reference amplitude, reference frequency step and blanking count are sampled only at the carrier valley, so each carrier period runs on one consistent setting. The polarity flag is an asynchronous input and passes through a synchronizer.

Top module: `spwm3_polarity_mod`

## Requirements
- R1: While reset (active-low, synchronous) is asserted, and from reset release until the second carrier valley has been clocked, all six gate outputs are 0.
- R2: The carrier count starts at 0, steps by one up to the period value P, then steps down to 0, so one carrier period is 2P clocks. The count 0 is the valley. A period input below 2 is used as 2.
- R3: A 16-bit phase accumulator adds the frequency step on every clock. Leg k (k = 0, 1, 2) adds the offset floor(k·65536/3) and uses the top 6 bits as a table index i. With x = i mod 32, the table value is s = floor(x·(32−x)·127/256), and it is negated when i ≥ 32.
- R4: With carrier count c, period P and amplitude A (8 bits), the leg's PWM state is 1 exactly when c < floor(P/2) + floor(s·A·P / 65536), compared as signed integers.
- R5: Within leg k, gate bit 2k (upper switch) is the PWM state XOR the synchronized polarity flag, and gate bit 2k+1 (lower switch) is the complement of bit 2k. The result is that 0/0→0, 0/1→1, 1/0→1 and 1/1→0 on the upper switch, and a polarity change swaps which switch is on.
- R6: The polarity input passes through two flip-flops before it affects the leg targets. The leg state registers the resulting target on the following clock.
- R7: When a leg's target differs from its applied state and the blanking count B is non-zero, both gates of that leg are 0 for exactly B clocks, and the new state appears on the clock after that. With B = 0 the new state appears one clock after the target changes.
- R8: Period, amplitude, frequency step and blanking count are sampled only on a clock where the carrier count is at the valley. Changes at other times take effect at the next valley.
- R9: The two gates of one leg are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| car_period_in | input | CW | Carrier peak count P (clamped to at least 2) |
| ref_amp_in | input | AW | Reference amplitude A |
| ref_step_in | input | PW | Phase accumulator step per clock |
| blank_in | input | BW | Blanking clocks before a leg changes state |
| neg_pol_in | input | 1 | 1 while the supply square wave is negative (asynchronous) |
| gate_o | output | 6 | Gate commands: bit 2k upper, bit 2k+1 lower switch of leg k |

## Verification
Gate outputs depend on registered state only. A wrong carrier count, phase accumulator value or shadow setting therefore shows as a misplaced PWM edge within one carrier period, or within a few hundred clocks when the phase has to sweep into the affected region of the sine table. A synchronizer that is one flop short or long moves every polarity-driven swap by a clock on the very next toggle. A wrong blanking counter or leg state shows at once as a blank window that is too short or too long, or as an overlapping pair. The bench therefore compares all six gates with an arithmetic model on every clock, across a sweep of periods, amplitudes, blanking counts and polarity toggle rates.

// File: rtl/spwm3_pkg.sv
// spwm3_pkg: shared helpers for the polarity-corrected modulator.
// Assumes table depth is a power of two with at least 4 entries.
package spwm3_pkg;

    // Parabolic half-wave approximation of a sine, peak 127, negated in the second half.
    function automatic logic signed [7:0] sine_at(input int unsigned idx, input int unsigned tw);
        int unsigned half;
        int unsigned x;
        int unsigned mag;
        logic signed [7:0] m8;
        half = 1 << (tw - 1);
        x    = idx % half;
        mag  = (x * (half - x) * 127) / ((half * half) / 4);
        m8   = 8'(mag);
        return (idx >= half) ? -m8 : m8;
    endfunction

endpackage

// File: rtl/spwm3_sync.sv
// spwm3_sync: two-flop synchronizer for the asynchronous supply-polarity flag.
// Assumes the flag stays stable for at least two clocks between edges.
module spwm3_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic s1;

    // Shift the flag through two stages into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1    <= 1'b0;
            q_out <= 1'b0;
        end else begin
            s1    <= d_in;
            q_out <= s1;
        end
    end
endmodule

// File: rtl/spwm3_carrier.sv
// spwm3_carrier: symmetric up/down triangular carrier with a shadow copy of
// all run-time settings, taken only at the valley (count 0).
// Assumes period inputs below 2 are meaningless and clamps them to 2.
module spwm3_carrier #(
    parameter int CW = 8,
    parameter int AW = 8,
    parameter int PW = 16,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] per_in,
    input  logic [AW-1:0] amp_in,
    input  logic [PW-1:0] step_in,
    input  logic [BW-1:0] blank_in,
    output logic [CW-1:0] cnt,
    output logic          valley,
    output logic [CW-1:0] per_q,
    output logic [AW-1:0] amp_q,
    output logic [PW-1:0] step_q,
    output logic [BW-1:0] blank_q
);
    localparam logic [CW-1:0] PER_MIN = CW'(2);

    logic up;

    // Valley marks the start of a carrier period.
    always_comb valley = (cnt == '0);

    // Advance the triangle and refresh the shadow settings at the valley.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            up      <= 1'b1;
            per_q   <= PER_MIN;
            amp_q   <= '0;
            step_q  <= '0;
            blank_q <= '0;
        end else if (valley) begin
            cnt     <= CW'(1);
            up      <= 1'b1;
            per_q   <= (per_in < PER_MIN) ? PER_MIN : per_in;
            amp_q   <= amp_in;
            step_q  <= step_in;
            blank_q <= blank_in;
        end else if (up) begin
            if (cnt == per_q) begin
                up  <= 1'b0;
                cnt <= cnt - CW'(1);
            end else begin
                cnt <= cnt + CW'(1);
            end
        end else begin
            cnt <= cnt - CW'(1);
        end
    end
endmodule

// File: rtl/spwm3_leg.sv
// spwm3_leg: one output leg. Looks up the sine table, compares the scaled
// reference with the carrier, applies the polarity XOR and drives a
// complementary pair with a blanking gap on every state change.
// Assumes run stays low until the first full carrier period has elapsed.
module spwm3_leg #(
    parameter int CW = 8,
    parameter int AW = 8,
    parameter int TW = 6,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] idx,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] per_q,
    input  logic [AW-1:0] amp_q,
    input  logic          pol,
    input  logic [BW-1:0] blank_q,
    output logic [1:0]    gate
);
    localparam int DEPTH = 1 << TW;
    localparam int MW    = 8 + (AW + 1) + (CW + 1) + 1;
    localparam int SH    = AW + 8;

    logic signed [7:0]    rom [DEPTH];
    logic signed [MW-1:0] prod;
    logic signed [MW-1:0] lvl;
    logic signed [MW-1:0] cnt_s;
    logic                 pwm;
    logic                 target;
    logic                 cur;
    logic [BW-1:0]        blk;
    logic                 on;

    // Constant sine table computed at elaboration.
    for (genvar i = 0; i < DEPTH; i++) begin : g_rom
        assign rom[i] = spwm3_pkg::sine_at(i, TW);
    end

    // Scale the reference around mid-carrier and compare with the count.
    always_comb begin
        prod   = MW'(rom[idx]) * MW'(signed'({1'b0, amp_q})) * MW'(signed'({1'b0, per_q}));
        lvl    = MW'(signed'({1'b0, per_q >> 1})) + (prod >>> SH);
        cnt_s  = MW'(signed'({1'b0, cnt}));
        pwm    = (cnt_s < lvl);
        target = pwm ^ pol;
    end

    // Track the applied state, inserting a blanking gap before each change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= 1'b0;
            blk <= '0;
        end else if (!run) begin
            cur <= target;
            blk <= '0;
        end else if (blk != '0) begin
            blk <= blk - BW'(1);
            if (blk == BW'(1)) cur <= target;
        end else if (target != cur) begin
            if (blank_q == '0) cur <= target;
            else               blk <= blank_q;
        end
    end

    // Drive the complementary pair; both off while blanking or not running.
    always_comb begin
        on   = run && (blk == '0);
        gate = {on & ~cur, on & cur};
    end
endmodule

// File: rtl/spwm3_polarity_mod.sv
// spwm3_polarity_mod: three-phase sine-triangle modulator whose gate pattern
// is inverted while the supply square wave is negative. Holds all gates off
// through reset and the first carrier period.
// Assumes neg_pol_in is asynchronous and slow compared with clk.
module spwm3_polarity_mod #(
    parameter int CW = 8,
    parameter int AW = 8,
    parameter int PW = 16,
    parameter int TW = 6,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] car_period_in,
    input  logic [AW-1:0] ref_amp_in,
    input  logic [PW-1:0] ref_step_in,
    input  logic [BW-1:0] blank_in,
    input  logic          neg_pol_in,
    output logic [5:0]    gate_o
);
    localparam longint FULL = longint'(1) << PW;

    logic [CW-1:0] cnt_w;
    logic          valley_w;
    logic [CW-1:0] per_w;
    logic [AW-1:0] amp_w;
    logic [PW-1:0] step_w;
    logic [BW-1:0] blank_w;
    logic          pol_w;
    logic [PW-1:0] ph;
    logic          seen;
    logic          run;

    spwm3_sync u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (neg_pol_in),
        .q_out (pol_w)
    );

    spwm3_carrier #(.CW(CW), .AW(AW), .PW(PW), .BW(BW)) u_car (
        .clk      (clk),
        .rst_n    (rst_n),
        .per_in   (car_period_in),
        .amp_in   (ref_amp_in),
        .step_in  (ref_step_in),
        .blank_in (blank_in),
        .cnt      (cnt_w),
        .valley   (valley_w),
        .per_q    (per_w),
        .amp_q    (amp_w),
        .step_q   (step_w),
        .blank_q  (blank_w)
    );

    // Phase accumulator shared by all three legs.
    always_ff @(posedge clk) begin
        if (!rst_n) ph <= '0;
        else        ph <= ph + step_w;
    end

    // Enable gates once a full carrier period has passed after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen <= 1'b0;
            run  <= 1'b0;
        end else if (valley_w) begin
            seen <= 1'b1;
            if (seen) run <= 1'b1;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_leg
        localparam logic [PW-1:0] OFS = PW'((longint'(k) * FULL) / 3);
        logic [PW-1:0] sum;
        assign sum = ph + OFS;

        spwm3_leg #(.CW(CW), .AW(AW), .TW(TW), .BW(BW)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .run     (run),
            .idx     (sum[PW-1 -: TW]),
            .cnt     (cnt_w),
            .per_q   (per_w),
            .amp_q   (amp_w),
            .pol     (pol_w),
            .blank_q (blank_w),
            .gate    (gate_o[2*k+1 : 2*k])
        );
    end
endmodule

// File: rtl/spwm3_chk.sv
// spwm3_chk: temporal checks on the modulator, bound into every instance.
module spwm3_chk #(
    parameter int CW = 8,
    parameter int BW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [5:0]    gate_o,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] per_q,
    input logic          valley,
    input logic [BW-1:0] blank_q
);
    for (genvar k = 0; k < 3; k++) begin : g_leg_chk
        // R9
        no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(gate_o[2*k] && gate_o[2*k+1]));

        // R7
        swap_up_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_o[2*k+1] && $past(gate_o[2*k])) |-> ($past(blank_q) == '0));

        // R7
        swap_dn_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (gate_o[2*k] && $past(gate_o[2*k+1])) |-> ($past(blank_q) == '0));
    end

    // R2
    carrier_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= per_q);

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(valley) |-> $stable(per_q));

    // R1
    post_reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gate_o == 6'b0));
endmodule

bind spwm3_polarity_mod spwm3_chk #(.CW(CW), .BW(BW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .gate_o  (gate_o),
    .cnt     (cnt_w),
    .per_q   (per_w),
    .valley  (valley_w),
    .blank_q (blank_w)
);

// File: tb/test_spwm3_polarity_mod.sv
// test_spwm3_polarity_mod: sweeps period, amplitude, blanking and polarity
// rates and compares every gate on every clock with an arithmetic model.
module test_spwm3_polarity_mod;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  car_period_in = 8'd4;
    logic [7:0]  ref_amp_in = 8'd0;
    logic [15:0] ref_step_in = 16'd0;
    logic [3:0]  blank_in = 4'd0;
    logic        neg_pol_in = 1'b0;
    logic [5:0]  gate_o;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    started = 0;
    bit    done = 0;
    string sec_tag = "R1";

    always #5 clk = ~clk;

    spwm3_polarity_mod i_spwm3_polarity_mod (
        .clk           (clk),
        .rst_n         (rst_n),
        .car_period_in (car_period_in),
        .ref_amp_in    (ref_amp_in),
        .ref_step_in   (ref_step_in),
        .blank_in      (blank_in),
        .neg_pol_in    (neg_pol_in),
        .gate_o        (gate_o)
    );

    // Model state, built from the requirement text.
    int          mc, mper, mamp, mblank;
    bit          mup, ms1, ms2, mseen, mrun;
    logic [15:0] mph, mstep;
    bit          mcur [3];
    int          mblk [3];

    function automatic int sine_m(int i);
        int x, mag;
        x   = i % 32;
        mag = (x * (32 - x) * 127) / 256;
        return (i >= 32) ? -mag : mag;
    endfunction

    function automatic bit pwm_m(int k);
        logic [15:0] a;
        int s, prod, lvl;
        a    = mph + 16'((k * 65536) / 3);
        s    = sine_m(int'(a[15:10]));
        prod = s * mamp * mper;
        lvl  = mper / 2 + (prod >>> 16);
        return mc < lvl;
    endfunction

    function automatic logic [5:0] exp_gates();
        logic [5:0] g;
        for (int k = 0; k < 3; k++) begin
            bit on;
            on = mrun && (mblk[k] == 0);
            g[2*k]   = on & mcur[k];
            g[2*k+1] = on & ~mcur[k];
        end
        return g;
    endfunction

    // R2 R3 R4 R5 R6 R7 R8: reference model stepped on each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        cyc <= cyc + 1;
        if (!rst_n) begin
            mc = 0; mup = 1; mper = 2; mamp = 0; mstep = 0; mblank = 0;
            ms1 = 0; ms2 = 0; mph = 0; mseen = 0; mrun = 0;
            for (int k = 0; k < 3; k++) begin mcur[k] = 0; mblk[k] = 0; end
        end else begin
            bit tg [3];
            bit v;
            for (int k = 0; k < 3; k++) tg[k] = pwm_m(k) ^ ms2;
            v = (mc == 0);
            for (int k = 0; k < 3; k++) begin
                if (!mrun) begin mcur[k] = tg[k]; mblk[k] = 0; end
                else if (mblk[k] != 0) begin
                    if (mblk[k] == 1) mcur[k] = tg[k];
                    mblk[k] = mblk[k] - 1;
                end else if (tg[k] != mcur[k]) begin
                    if (mblank == 0) mcur[k] = tg[k];
                    else mblk[k] = mblank;
                end
            end
            if (v) begin
                if (mseen) mrun = 1;
                mseen = 1;
            end
            mph = mph + mstep;
            ms2 = ms1;
            ms1 = neg_pol_in;
            if (v) begin
                mc = 1; mup = 1;
                mper = (car_period_in < 2) ? 2 : int'(car_period_in);
                mamp = int'(ref_amp_in);
                mstep = ref_step_in;
                mblank = int'(blank_in);
            end else if (mup) begin
                if (mc == mper) begin mup = 0; mc = mc - 1; end
                else mc = mc + 1;
            end else begin
                mc = mc - 1;
            end
        end
    end

    // Compare outputs away from the active edge.
    always @(negedge clk) begin
        if (started && !done) begin
            logic [5:0] e;
            string t;
            bit blanking;
            e = exp_gates();
            blanking = (mblk[0] != 0) || (mblk[1] != 0) || (mblk[2] != 0);
            if (!rst_n || !mrun) t = "R1";
            else if (blanking) t = "R7";
            else t = sec_tag;
            checks++;
            if (gate_o !== e) begin
                errors++;
                $display("FAIL %s gates actual=%b expected=%b at cycle %0d", t, gate_o, e, cyc);
            end
            checks++;
            for (int k = 0; k < 3; k++) begin
                if (gate_o[2*k] === 1'b1 && gate_o[2*k+1] === 1'b1) begin
                    errors++;
                    $display("FAIL R9 leg %0d actual=11 expected=not both on", k);
                end
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc >= 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=finish", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic run_cfg(int p, int b, int a, int st, int n, int polper);
        @(negedge clk);
        car_period_in = 8'(p);
        blank_in      = 4'(b);
        ref_amp_in    = 8'(a);
        ref_step_in   = 16'(st);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (polper > 0 && (i % polper) == polper - 1) neg_pol_in = ~neg_pol_in;
        end
    endtask

    initial begin
        // R1: reset state and warm-up period
        sec_tag = "R1";
        repeat (4) @(negedge clk);
        checks++;
        if (gate_o !== 6'b0) begin
            errors++;
            $display("FAIL R1 reset gates actual=%b expected=000000", gate_o);
        end
        rst_n = 1'b1;
        // R4: static references, wide carrier, polarity held
        sec_tag = "R4";
        run_cfg(100, 0, 255, 0, 450, 0);
        // R5: polarity toggles against mid-level references
        sec_tag = "R5";
        run_cfg(10, 0, 0, 0, 200, 7);
        // R2 R3: period, amplitude and blanking sweep with moving phase
        for (int pi = 0; pi < 5; pi++) begin
            for (int bi = 0; bi < 3; bi++) begin
                for (int ai = 0; ai < 3; ai++) begin
                    int pv [5] = '{1, 2, 3, 7, 12};
                    int bv [3] = '{0, 1, 3};
                    int av [3] = '{0, 200, 255};
                    sec_tag = (ai == 0) ? "R2" : "R3";
                    run_cfg(pv[pi], bv[bi], av[ai], 1500 + 97 * ai, 130, 0);
                end
            end
        end
        // R6: single-clock and fast polarity pulses
        sec_tag = "R6";
        run_cfg(6, 0, 180, 700, 150, 1);
        run_cfg(6, 2, 180, 700, 150, 3);
        // R7: long blanking with frequent state changes
        sec_tag = "R7";
        run_cfg(5, 15, 255, 2300, 300, 11);
        // R8: settings changed mid-period, several times per carrier period
        sec_tag = "R8";
        for (int j = 0; j < 12; j++) run_cfg(20 + 3 * j, j % 4, 40 + 17 * j, 300 * j, 13, 5);
        // R1: reset asserted again mid-run
        sec_tag = "R1";
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (gate_o !== 6'b0) begin
            errors++;
            $display("FAIL R1 re-reset gates actual=%b expected=000000", gate_o);
        end
        rst_n = 1'b1;
        run_cfg(9, 1, 220, 900, 120, 13);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule